// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one parallel word at a time over a three-wire synchronous serial link: a data output line, a data input line and a serial clock pin that can either drive or listen. A single-cycle start strobe loads the word, the port shifts it out one bit per clock period while it captures the input line, and a done flag goes high once the whole word has been exchanged. The received word then appears on a parallel output. The order of bits on the wire, most significant or least significant first, is fixed when the block is built.

The serial clock comes from one of two places, chosen at run time by a control input. In internal mode the port makes its own clock from the system clock. One instruction cycle is a fixed number of system clocks, and the serial period is that cycle times a power-of-two prescaler ratio. Between transfers the clock idles high. In external mode the clock pin is an input: it passes through a two-flop synchronizer, and its edges are detected in the system clock domain. When serial operation is switched off, the clock pin becomes a free-running divided clock output taken from a second prescaler ratio, and any transfer in progress is abandoned.

The data output changes on the falling edge of the serial clock. The data input is sampled on the rising edge. The pin driver sits outside the block: the block supplies the level for the clock pin, its output enable, and the level read back from the pin.

Top module: `sync_serial_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy`, `done`, `sdo` and `rx_word` are all zero and `sck_oe` is 1.
- R2: When `ser_en` is 1 and the port is idle, a start pulse loads `tx_word`. `busy` is 1 from the next cycle, `done` clears, and `sdo` shows the first bit to be sent.
- R3: With `MSB_FIRST`=1, bit WORD_W-1 of `tx_word` goes out first, and the first bit received lands in bit WORD_W-1 of `rx_word`. With `MSB_FIRST`=0, bit 0 goes out first and the first bit received lands in bit 0.
- R4: In internal mode (`ext_clk_sel`=0) the serial clock stays low, then high, for CYC_DIV*2^DIV_LOG2/2 system clocks each. The low half of each period comes first, counted from the cycle after the start, and the clock idles high whenever no transfer is running.
- R5: `sdo` advances to the next bit only on a falling serial-clock edge. `sdi` is sampled only on a rising serial-clock edge.
- R6: On the WORD_W-th rising edge `busy` clears, `done` sets and `rx_word` takes the received word. `rx_word` changes at no other time, and `busy` and `done` are never 1 together.
- R7: In external mode (`ext_clk_sel`=1) `sck_oe` is 0, and edges on `sck_i` clock the transfer. The shift register acts on the third system-clock edge that samples the new pin level.
- R8: While `ser_en` is 0, `sck_oe` is 1 and `sck_o` toggles every CYC_DIV*2^CK_LOG2/2 system clocks, counted from reset. Clearing `ser_en` during a transfer ends it with `busy` 0 in the next cycle, without setting `done` or changing `rx_word`.
- R9: A start pulse is ignored while `busy` is 1 or while `ser_en` is 0.
- R10: `done` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | 1 selects serial operation; 0 turns the clock pin into a divided clock output |
| ext_clk_sel | input | 1 | 1 takes the shift clock from `sck_i`; 0 generates it internally |
| start | input | 1 | Single-cycle pulse that begins a transfer |
| tx_word | input | WORD_W | Word to send, loaded on an accepted start |
| rx_word | output | WORD_W | Last completely received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed; cleared by the next accepted start |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sck_i | input | 1 | Level read back from the clock pin |
| sck_o | output | 1 | Level to drive on the clock pin |
| sck_oe | output | 1 | Output enable for the clock pin |

## Verification
The assertions take four things for granted about the inputs. `ext_clk_sel` changes only while the port is idle. `start` is a single-cycle pulse. An external clock's high and low phases each last well beyond the three-flop detection latency. `sdi` holds steady from before a sampling edge until after the port has acted on it. The stimulus respects all four: mode and enable change only between transfers (the one exception is the deliberate abort), the external clock uses ten-cycle phases, and the input bit is updated from the reference model's count of rising edges, one half cycle after each capture. Both bit orders run side by side on the same stimulus, and a behavioural model is compared against each of them on every clock.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // one decoded serial-clock event per system clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;

  // system clocks per half serial period for a cycle length and power-of-two ratio
  function automatic int half_period(input int cyc, input int lg);
    return (cyc * (1 << lg)) / 2;
  endfunction

endpackage

// File: rtl/sport_divider.sv
module sport_divider #(
  parameter int HALF = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tgl
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)        cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tgl = en && (cnt == LAST);
endmodule

// File: rtl/sport_edge_sync.sv
module sport_edge_sync
  import sport_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin,
  output sck_evt_t evt
);
  // [0],[1] synchronizer, [2] history for edge detection
  logic [2:0] sq;

  always_ff @(posedge clk) begin
    if (rst) sq <= 3'b111;
    else     sq <= {sq[1:0], pin};
  end

  assign evt.rise = sq[1] & ~sq[2];
  assign evt.fall = ~sq[1] & sq[2];
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter
  import sport_pkg::*;
#(
  parameter int W         = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_en,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  sck_evt_t     evt,
  input  logic         sdi,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [W-1:0]  sh_nx;
  logic          out_bit;
  logic          first_bit;
  logic [CW-1:0] cnt;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sh_nx     = {sh[W-2:0], sdi};
      assign out_bit   = sh[W-1];
      assign first_bit = tx_word[W-1];
    end else begin : g_lsb
      assign sh_nx     = {sdi, sh[W-1:1]};
      assign out_bit   = sh[0];
      assign first_bit = tx_word[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sdo     <= 1'b0;
      rx_word <= '0;
    end else if (!ser_en) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (evt.fall) sdo <= out_bit;
      if (evt.rise) begin
        sh <= sh_nx;
        if (cnt == LAST) begin
          cnt     <= '0;
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= sh_nx;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (start) begin
      sh   <= tx_word;
      sdo  <= first_bit;
      cnt  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sport_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter bit MSB_FIRST = 1'b1,
  parameter int CYC_DIV   = 6,
  parameter int DIV_LOG2  = 1,
  parameter int CK_LOG2   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_en,
  input  logic              ext_clk_sel,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              sdo,
  input  logic              sdi,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe
);
  localparam int HALF_SER = half_period(CYC_DIV, DIV_LOG2);
  localparam int HALF_CK  = half_period(CYC_DIV, CK_LOG2);

  logic     ser_tgl;
  logic     ck_tgl;
  logic     sck_int;
  logic     ck_q;
  sck_evt_t int_evt;
  sck_evt_t ext_evt;
  sck_evt_t evt;

  // internal shift clock, runs only during an internally clocked transfer
  sport_divider #(.HALF(HALF_SER)) u_ser_div (
    .clk (clk),
    .rst (rst),
    .en  (busy && ser_en && !ext_clk_sel),
    .tgl (ser_tgl)
  );

  // free-running clock output used when serial operation is off
  sport_divider #(.HALF(HALF_CK)) u_ck_div (
    .clk (clk),
    .rst (rst),
    .en  (1'b1),
    .tgl (ck_tgl)
  );

  sport_edge_sync u_sync (
    .clk (clk),
    .rst (rst),
    .pin (sck_i),
    .evt (ext_evt)
  );

  always_ff @(posedge clk) begin
    if (rst || !ser_en)                   sck_int <= 1'b1;
    else if (busy && !ext_clk_sel && ser_tgl) sck_int <= ~sck_int;
  end

  always_ff @(posedge clk) begin
    if (rst)         ck_q <= 1'b0;
    else if (ck_tgl) ck_q <= ~ck_q;
  end

  assign int_evt.fall = ser_tgl & sck_int;
  assign int_evt.rise = ser_tgl & ~sck_int;
  assign evt          = ext_clk_sel ? ext_evt : int_evt;

  sport_shifter #(.W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .ser_en  (ser_en),
    .start   (start),
    .tx_word (tx_word),
    .evt     (evt),
    .sdi     (sdi),
    .sdo     (sdo),
    .busy    (busy),
    .done    (done),
    .rx_word (rx_word)
  );

  assign sck_o  = ser_en ? sck_int : ck_q;
  assign sck_oe = ~(ser_en & ext_clk_sel);
endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_en,
  input logic         ext_clk_sel,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         sdo,
  input logic         sck_o,
  input logic [W-1:0] rx_word
);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R6
  done_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> $rose(done));

  // R5
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !ext_clk_sel && $past(ser_en) && !$past(ext_clk_sel) && !$stable(sdo))
      |-> ($fell(sck_o) || $past(start)));

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !ext_clk_sel && !busy) |-> sck_o);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !busy) |=> (busy == $past(start)));

  // R8
  off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> !busy);
endmodule

bind sync_serial_port sport_chk #(.W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ser_en      (ser_en),
  .ext_clk_sel (ext_clk_sel),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .sdo         (sdo),
  .sck_o       (sck_o),
  .rx_word     (rx_word)
);

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps

module sport_ref #(
  parameter int W         = 8,
  parameter bit MSB_FIRST = 1'b1,
  parameter int HALF      = 6,
  parameter int CKH       = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_en,
  input  logic         ext_sel,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         sdi,
  input  logic         sck_i,
  output logic         e_busy,
  output logic         e_done,
  output logic         e_sdo,
  output logic         e_sck,
  output logic         e_ck,
  output logic [W-1:0] e_rx,
  output int           e_rises
);
  int t;
  int ckc;
  logic h1, h2, h3;
  logic x_rise, x_fall, rs, fl;
  logic [W-1:0] txw;
  logic [W-1:0] acc;

  function automatic int ord(input int i);
    return MSB_FIRST ? (W - 1 - i) : i;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_busy = 0; e_done = 0; e_sdo = 0; e_sck = 1; e_ck = 0; e_rx = '0;
      e_rises = 0; t = 0; ckc = 0; h1 = 1; h2 = 1; h3 = 1; txw = '0; acc = '0;
    end else begin
      ckc = ckc + 1;
      if (ckc == CKH) begin ckc = 0; e_ck = !e_ck; end
      x_rise = h2 && !h3;
      x_fall = !h2 && h3;
      h3 = h2; h2 = h1; h1 = sck_i;
      if (!ser_en) begin
        e_busy = 0; e_sck = 1; t = 0;
      end else if (e_busy) begin
        rs = 0; fl = 0;
        if (ext_sel) begin
          rs = x_rise; fl = x_fall;
        end else begin
          t = t + 1;
          if (t == HALF) begin
            t = 0;
            if (e_sck) fl = 1; else rs = 1;
            e_sck = !e_sck;
          end
        end
        if (fl) e_sdo = txw[ord(e_rises)];
        if (rs) begin
          acc[ord(e_rises)] = sdi;
          e_rises = e_rises + 1;
          if (e_rises == W) begin e_busy = 0; e_done = 1; e_rx = acc; end
        end
      end else if (start) begin
        txw = tx; e_busy = 1; e_done = 0; e_rises = 0; t = 0; e_sdo = tx[ord(0)];
      end
    end
  end
endmodule

module tb_sync_serial_port;
  localparam int W    = 8;
  localparam int HALF = 6;
  localparam int CKH  = 12;

  logic clk = 0;
  logic rst = 1;
  logic ser_en = 0, ext_sel = 0, start = 0, sdi = 0, sck_i = 1;
  logic [W-1:0] tx = '0;
  logic [W-1:0] pat = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [W-1:0] rx_m, rx_l;
  logic busy_m, busy_l, done_m, done_l, sdo_m, sdo_l, sck_m, sck_l, oe_m, oe_l;
  logic e_busy_m, e_done_m, e_sdo_m, e_sck_m, e_ck_m;
  logic e_busy_l, e_done_l, e_sdo_l, e_sck_l, e_ck_l;
  logic [W-1:0] e_rx_m, e_rx_l;
  int rises_m, rises_l;

  always #2 clk = ~clk;

  sync_serial_port #(.WORD_W(W), .MSB_FIRST(1'b1)) dut (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ext_clk_sel(ext_sel), .start(start),
    .tx_word(tx), .rx_word(rx_m), .busy(busy_m), .done(done_m), .sdo(sdo_m),
    .sdi(sdi), .sck_i(sck_i), .sck_o(sck_m), .sck_oe(oe_m));

  sync_serial_port #(.WORD_W(W), .MSB_FIRST(1'b0)) dut_lsb (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ext_clk_sel(ext_sel), .start(start),
    .tx_word(tx), .rx_word(rx_l), .busy(busy_l), .done(done_l), .sdo(sdo_l),
    .sdi(sdi), .sck_i(sck_i), .sck_o(sck_l), .sck_oe(oe_l));

  sport_ref #(.W(W), .MSB_FIRST(1'b1), .HALF(HALF), .CKH(CKH)) ref_m (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ext_sel(ext_sel), .start(start), .tx(tx),
    .sdi(sdi), .sck_i(sck_i), .e_busy(e_busy_m), .e_done(e_done_m), .e_sdo(e_sdo_m),
    .e_sck(e_sck_m), .e_ck(e_ck_m), .e_rx(e_rx_m), .e_rises(rises_m));

  sport_ref #(.W(W), .MSB_FIRST(1'b0), .HALF(HALF), .CKH(CKH)) ref_l (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ext_sel(ext_sel), .start(start), .tx(tx),
    .sdi(sdi), .sck_i(sck_i), .e_busy(e_busy_l), .e_done(e_done_l), .e_sdo(e_sdo_l),
    .e_sck(e_sck_l), .e_ck(e_ck_l), .e_rx(e_rx_l), .e_rises(rises_l));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // input bit for the next rising edge, first stream bit is pat[W-1]
  always @(negedge clk) sdi = (rises_m < W) ? pat[W-1-rises_m] : 1'b0;

  // every-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4/R8", "sck_o msb", sck_m, ser_en ? e_sck_m : e_ck_m);
      chk("R4/R8", "sck_o lsb", sck_l, ser_en ? e_sck_l : e_ck_l);
      chk("R7", "sck_oe", oe_m, (ser_en && ext_sel) ? 1'b0 : 1'b1);
      chk("R5", "sdo msb", sdo_m, e_sdo_m);
      chk("R5", "sdo lsb", sdo_l, e_sdo_l);
      chk("R2", "busy msb", busy_m, e_busy_m);
      chk("R2", "busy lsb", busy_l, e_busy_l);
      chk("R6", "done msb", done_m, e_done_m);
      chk("R6", "done lsb", done_l, e_done_l);
      chk("R3", "rx_word msb", rx_m, e_rx_m);
      chk("R3", "rx_word lsb", rx_l, e_rx_l);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start(input logic [W-1:0] word);
    tx = word; start = 1; step(1); start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy_m; i++) step(1);
  endtask

  task automatic ext_clock_word();
    for (int b = 0; b < W; b++) begin
      sck_i = 0; step(10);
      sck_i = 1; step(10);
    end
    step(6);
  endtask

  initial begin
    step(4);
    // R1 reset state
    chk("R1", "busy in reset", busy_m, 1'b0);
    chk("R1", "done in reset", done_m, 1'b0);
    chk("R1", "sdo in reset", sdo_m, 1'b0);
    chk("R1", "rx_word in reset", rx_m, '0);
    chk("R1", "sck_oe in reset", oe_m, 1'b1);
    rst = 0;
    step(60);

    // R9 start ignored with serial off
    pulse_start(8'hE7);
    chk("R9", "start while off", busy_m, 1'b0);
    ser_en = 1; step(2);

    // internal transfer
    pat = 8'h1E; pulse_start(8'hA5);
    chk("R2", "busy after start", busy_m, 1'b1);
    wait_idle(); step(1);
    chk("R3", "rx msb-first", rx_m, 8'h1E);
    chk("R3", "rx lsb-first", rx_l, rev(8'h1E));
    chk("R6", "done after word", done_m, 1'b1);

    // R9 start during a transfer is ignored
    pat = 8'hC3; pulse_start(8'h5A);
    step(20); pulse_start(8'hFF);
    wait_idle(); step(1);
    chk("R9", "rx after ignored start", rx_m, 8'hC3);
    chk("R9", "rx lsb after ignored start", rx_l, rev(8'hC3));

    pat = 8'hFF; pulse_start(8'h00); wait_idle(); step(1);
    chk("R3", "rx all ones", rx_m, 8'hFF);
    pat = 8'h00; pulse_start(8'hFF); wait_idle(); step(1);
    chk("R3", "rx all zeros", rx_l, 8'h00);

    step(30);
    chk("R10", "done holds", done_m, 1'b1);

    // R8 abort by clearing ser_en
    pat = 8'h55; pulse_start(8'h81); step(30);
    ser_en = 0; step(1);
    chk("R8", "busy after abort", busy_m, 1'b0);
    chk("R8", "done after abort", done_m, 1'b0);
    chk("R8", "rx after abort", rx_m, 8'h00);
    step(40);
    ser_en = 1; step(2);

    // R7 external clock
    ext_sel = 1; step(3);
    chk("R7", "sck_oe external", oe_m, 1'b0);
    pat = 8'h69; pulse_start(8'h96);
    ext_clock_word();
    chk("R7", "done external", done_m, 1'b1);
    chk("R7", "rx external msb", rx_m, 8'h69);
    chk("R7", "rx external lsb", rx_l, rev(8'h69));

    ext_sel = 0; step(3);
    pat = 8'hA7; pulse_start(8'h3C); wait_idle(); step(1);
    chk("R4", "rx back internal", rx_m, 8'hA7);
    step(5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule